// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides, once per clock, whether the core enters a system-reset exception or a machine-check exception. When it accepts one, it captures both save/restore words, forms the rewritten machine state word and presents a redirect target address with a single-cycle strobe. The rest of the core uses that strobe to load the state word and fetch from the target.

System reset is requested by either a soft or a hard reset request and cannot be masked. A machine check has five possible sources: the machine-check pin, a transfer-error acknowledge, a bus address parity error, a bus data parity error and a cache parity error. A machine check is gated by the machine-check enable bit of the current state word. If a machine-check condition arrives while that bit is clear, no exception is taken. Instead, a sticky checkstop flag is raised, and only a hard reset request clears it.

Bit numbering throughout follows the most-significant-first convention: architectural bit k of a 32-bit word sits at vector index 31-k.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A soft or hard reset request sampled at a rising edge accepts system reset, whatever the state word holds; the redirect target is the vector base plus 0x100.
- R2: With the enable bit ME (arch bit 19, vector index 12) set, any of the five machine-check sources accepts a machine check; the target is the base plus 0x200.
- R3: With ME clear, a machine-check condition starts no redirect and leaves the save words, state output and target unchanged.
- R4: When reset and machine-check conditions are sampled in the same cycle, system reset is the one taken.
- R5: The vector base is 0x00000000 when IP (arch bit 25, vector index 6) is 0 and 0xFFF00000 when IP is 1; IP is read from the state word sampled at acceptance.
- R6: On acceptance, save word 0 receives the sampled next-instruction address.
- R7: On acceptance, save word 1 copies the state word at arch bits 0, 5 to 9 and 16 to 31, and is zero at arch bits 1 to 4 and 10 to 15.
- R8: When the corruption input is high at acceptance, arch bit 30 (vector index 1) of save word 1 is zero.
- R9: On acceptance, the new state word is the sampled word with arch bits 13, 16, 17, 18, 20, 21, 22, 23, 26, 27 and 30 cleared, arch bit 31 loaded from arch bit 15, and every other bit kept.
- R10: Outputs change one clock after the accepting edge; the strobe is high for exactly that cycle when no request follows, and all captured outputs hold between acceptances.
- R11: A machine-check condition with ME clear sets the sticky checkstop output unless a hard reset request is sampled in the same cycle. A hard reset request clears the flag, and a soft reset request does not.
- R12: After the reset input is released, the strobe, checkstop, target, save words and state output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst_req | input | 1 | Warm system-reset request |
| hard_rst_req | input | 1 | Hard system-reset request; also clears checkstop |
| mchk_pin | input | 1 | External machine-check request |
| xfer_err_ack | input | 1 | Qualified bus transfer-error acknowledge |
| bus_addr_par_err | input | 1 | Bus address parity error |
| bus_data_par_err | input | 1 | Bus data parity error |
| cache_par_err | input | 1 | Cache parity error |
| state_corrupt | input | 1 | Execution cannot resume reliably |
| next_pc | input | 32 | Address of the instruction that would run next |
| cur_state | input | 32 | Current machine state word |
| redirect_vld | output | 1 | One-cycle redirect strobe |
| redirect_addr | output | 32 | Exception target address |
| save0 | output | 32 | Save/restore word 0 |
| save1 | output | 32 | Save/restore word 1 |
| new_state | output | 32 | State word to load with the strobe |
| checkstop | output | 1 | Sticky checkstop flag |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a high base of 0xFFF00000, and offsets 0x100 and 0x200. It sweeps all 1024 combinations of the seven request inputs, the ME and IP bits and the corruption flag, with a different state word and address in each case. This covers every priority pairing, every single and multiple machine-check source with the enable set and clear, and both vector bases. It also covers checkstop being set and cleared under every mix of soft and hard reset. Each acceptance is followed by an idle cycle with unrelated address and state values, so the single-cycle strobe and the holding of the captured words are checked as well.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int WORD_W = 32;

  // architectural bit numbers (0 = most significant)
  localparam int A_POW = 13;
  localparam int A_ILE = 15;
  localparam int A_EE  = 16;
  localparam int A_PR  = 17;
  localparam int A_FP  = 18;
  localparam int A_ME  = 19;
  localparam int A_FE0 = 20;
  localparam int A_SE  = 21;
  localparam int A_BE  = 22;
  localparam int A_FE1 = 23;
  localparam int A_IP  = 25;
  localparam int A_IR  = 26;
  localparam int A_DR  = 27;
  localparam int A_RI  = 30;
  localparam int A_LE  = 31;

  // vector index of an architectural bit
  function automatic int vix(input int arch);
    return WORD_W - 1 - arch;
  endfunction

  // bits of the state word carried into save word 1
  function automatic logic [WORD_W-1:0] save1_keep();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < WORD_W; k++) begin
      if (k == 0 || (k >= 5 && k <= 9) || k >= 16) m[vix(k)] = 1'b1;
    end
    return m;
  endfunction

  // bits of the state word forced low on entry
  function automatic logic [WORD_W-1:0] entry_clear();
    logic [WORD_W-1:0] m;
    m = '0;
    m[vix(A_POW)] = 1'b1; m[vix(A_EE)]  = 1'b1; m[vix(A_PR)]  = 1'b1;
    m[vix(A_FP)]  = 1'b1; m[vix(A_FE0)] = 1'b1; m[vix(A_SE)]  = 1'b1;
    m[vix(A_BE)]  = 1'b1; m[vix(A_FE1)] = 1'b1; m[vix(A_IR)]  = 1'b1;
    m[vix(A_DR)]  = 1'b1; m[vix(A_RI)]  = 1'b1;
    return m;
  endfunction

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_SRST = 2'd1,
    EXC_MCHK = 2'd2
  } exc_kind_e;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int N_MC_SRC = 5
) (
  input  logic                soft_req,
  input  logic                hard_req,
  input  logic [N_MC_SRC-1:0] mc_src,
  input  logic                mc_enable,
  output exc_kind_e           kind,
  output logic                mc_blocked
);

  logic rst_any;
  logic mc_any;

  assign rst_any = soft_req | hard_req;
  assign mc_any  = |mc_src;

  // system reset first, machine check only when enabled
  always_comb begin
    kind = EXC_NONE;
    if (rst_any) begin
      kind = EXC_SRST;
    end else if (mc_any && mc_enable) begin
      kind = EXC_MCHK;
    end
  end

  assign mc_blocked = mc_any & ~mc_enable;

  always_comb begin
    if (rst_any) a_r4_reset_wins: assert (kind == EXC_SRST);
  end

endmodule

// File: rtl/exc_save_merge.sv
module exc_save_merge
  import exc_entry_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] cur_state,
  input  logic         corrupt,
  output logic [W-1:0] save1_nxt,
  output logic [W-1:0] state_nxt
);

  localparam logic [W-1:0] KEEP  = save1_keep();
  localparam logic [W-1:0] CLEAR = entry_clear();
  localparam int           RI_V  = vix(A_RI);
  localparam int           LE_V  = vix(A_LE);
  localparam int           ILE_V = vix(A_ILE);

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g == RI_V) begin : g_ri
      assign save1_nxt[g] = KEEP[g] & cur_state[g] & ~corrupt;
    end else if (KEEP[g]) begin : g_keep
      assign save1_nxt[g] = cur_state[g];
    end else begin : g_zero
      assign save1_nxt[g] = 1'b0;
    end

    if (g == LE_V) begin : g_le
      assign state_nxt[g] = cur_state[ILE_V];
    end else if (CLEAR[g]) begin : g_clr
      assign state_nxt[g] = 1'b0;
    end else begin : g_hold
      assign state_nxt[g] = cur_state[g];
    end
  end

  always_comb begin
    a_r7_cleared_fields: assert ((save1_nxt & ~KEEP) == '0);
    a_r9_le_from_ile: assert (state_nxt[LE_V] == cur_state[ILE_V]);
  end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] SRST_OFS  = 32'h0000_0100,
  parameter logic [ADDR_W-1:0] MCHK_OFS  = 32'h0000_0200
) (
  input  logic              ip_high,
  input  exc_kind_e         kind,
  output logic [ADDR_W-1:0] target
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ofs;

  assign base = ip_high ? HIGH_BASE : '0;

  always_comb begin
    case (kind)
      EXC_SRST: ofs = SRST_OFS;
      EXC_MCHK: ofs = MCHK_OFS;
      default:  ofs = '0;
    endcase
  end

  assign target = base + ofs;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFF0_0000,
  parameter logic [ADDR_W-1:0] SRST_OFS  = 32'h0000_0100,
  parameter logic [ADDR_W-1:0] MCHK_OFS  = 32'h0000_0200,
  parameter int                SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_req,
  input  logic              hard_rst_req,
  input  logic              mchk_pin,
  input  logic              xfer_err_ack,
  input  logic              bus_addr_par_err,
  input  logic              bus_data_par_err,
  input  logic              cache_par_err,
  input  logic              state_corrupt,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [31:0]       cur_state,
  output logic              redirect_vld,
  output logic [ADDR_W-1:0] redirect_addr,
  output logic [ADDR_W-1:0] save0,
  output logic [31:0]       save1,
  output logic [31:0]       new_state,
  output logic              checkstop
);

  localparam int N_MC_SRC = 5;
  localparam int ME_V     = vix(A_ME);
  localparam int IP_V     = vix(A_IP);
  localparam int EE_V     = vix(A_EE);
  localparam int LE_V     = vix(A_LE);
  localparam int ILE_V    = vix(A_ILE);

  // ---------------- reset synchroniser ----------------
  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_LEN-1];

  // ---------------- decision ----------------
  logic [N_MC_SRC-1:0] mc_src;
  exc_kind_e           kind;
  logic                mc_blocked;
  logic [31:0]         save1_nxt;
  logic [31:0]         state_nxt;
  logic [ADDR_W-1:0]   target;

  assign mc_src = {mchk_pin, xfer_err_ack, bus_addr_par_err,
                   bus_data_par_err, cache_par_err};

  exc_arbiter #(.N_MC_SRC(N_MC_SRC)) u_arb (
    .soft_req   (soft_rst_req),
    .hard_req   (hard_rst_req),
    .mc_src     (mc_src),
    .mc_enable  (cur_state[ME_V]),
    .kind       (kind),
    .mc_blocked (mc_blocked)
  );

  exc_save_merge #(.W(32)) u_merge (
    .cur_state (cur_state),
    .corrupt   (state_corrupt),
    .save1_nxt (save1_nxt),
    .state_nxt (state_nxt)
  );

  exc_vector_gen #(
    .ADDR_W(ADDR_W), .HIGH_BASE(HIGH_BASE),
    .SRST_OFS(SRST_OFS), .MCHK_OFS(MCHK_OFS)
  ) u_vec (
    .ip_high (cur_state[IP_V]),
    .kind    (kind),
    .target  (target)
  );

  // ---------------- next state ----------------
  logic              take;
  logic              vld_d;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] save0_d;
  logic [31:0]       save1_d;
  logic [31:0]       state_d;
  logic              cs_d;

  assign take = (kind != EXC_NONE);

  always_comb begin
    vld_d   = take;
    addr_d  = redirect_addr;
    save0_d = save0;
    save1_d = save1;
    state_d = new_state;
    if (take) begin
      addr_d  = target;
      save0_d = next_pc;
      save1_d = save1_nxt;
      state_d = state_nxt;
    end
  end

  always_comb begin
    cs_d = checkstop;
    if (hard_rst_req)    cs_d = 1'b0;
    else if (mc_blocked) cs_d = 1'b1;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      redirect_vld  <= 1'b0;
      redirect_addr <= '0;
      save0         <= '0;
      save1         <= '0;
      new_state     <= '0;
      checkstop     <= 1'b0;
    end else begin
      redirect_vld <= vld_d;
      checkstop    <= cs_d;
      if (take) begin
        redirect_addr <= addr_d;
        save0         <= save0_d;
        save1         <= save1_d;
        new_state     <= state_d;
      end
    end
  end

  // ---------------- assertions ----------------
  logic mc_any_p;
  assign mc_any_p = mchk_pin | xfer_err_ack | bus_addr_par_err
                  | bus_data_par_err | cache_par_err;

  a_r1_reset_target: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (soft_rst_req || hard_rst_req) |=> (redirect_vld &&
      redirect_addr == (($past(cur_state[IP_V]) ? HIGH_BASE : '0) + SRST_OFS)));

  a_r3_me_gates: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mc_any_p && !cur_state[ME_V] && !soft_rst_req && !hard_rst_req)
      |=> (!redirect_vld && $stable(save0) && $stable(new_state)));

  a_r6_save0_pc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (soft_rst_req || (mc_any_p && cur_state[ME_V])) |=> save0 == $past(next_pc));

  a_r9_entry_state: assert property (@(posedge clk) disable iff (!rst_sync_n)
    redirect_vld |-> (!new_state[EE_V] && new_state[LE_V] == new_state[ILE_V]));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (checkstop && !hard_rst_req) |=> checkstop);

  a_r11_hard_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hard_rst_req |=> !checkstop);

endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        soft_rst_req, hard_rst_req, mchk_pin, xfer_err_ack;
  logic        bus_addr_par_err, bus_data_par_err, cache_par_err;
  logic        state_corrupt;
  logic [31:0] next_pc, cur_state;
  logic        redirect_vld, checkstop;
  logic [31:0] redirect_addr, save0, save1, new_state;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n),
    .soft_rst_req(soft_rst_req), .hard_rst_req(hard_rst_req),
    .mchk_pin(mchk_pin), .xfer_err_ack(xfer_err_ack),
    .bus_addr_par_err(bus_addr_par_err), .bus_data_par_err(bus_data_par_err),
    .cache_par_err(cache_par_err), .state_corrupt(state_corrupt),
    .next_pc(next_pc), .cur_state(cur_state),
    .redirect_vld(redirect_vld), .redirect_addr(redirect_addr),
    .save0(save0), .save1(save1), .new_state(new_state),
    .checkstop(checkstop)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // architectural bit k lives at index 31-k
  function automatic logic abit(input logic [31:0] w, input int k);
    return w[31-k];
  endfunction

  function automatic logic [31:0] exp_save1(input logic [31:0] s, input logic corrupt);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 32; k++) begin
      if (k == 0 || (k >= 5 && k <= 9) || k >= 16) r[31-k] = s[31-k];
    end
    if (corrupt) r[31-30] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] exp_state(input logic [31:0] s);
    logic [31:0] r;
    int clr[11] = '{13, 16, 17, 18, 20, 21, 22, 23, 26, 27, 30};
    r = s;
    foreach (clr[i]) r[31-clr[i]] = 1'b0;
    r[31-31] = s[31-15];
    return r;
  endfunction

  task automatic idle_inputs(input logic [31:0] junk);
    soft_rst_req = 0; hard_rst_req = 0; mchk_pin = 0; xfer_err_ack = 0;
    bus_addr_par_err = 0; bus_data_par_err = 0; cache_par_err = 0;
    state_corrupt = junk[0];
    next_pc = junk ^ 32'hDEAD_0000;
    cur_state = ~junk;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] e_addr, e_s0, e_s1, e_st;
    logic        e_cs;
    rst_n = 1'b0;
    idle_inputs(32'h1234_5678);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 strobe", {31'b0, redirect_vld}, 32'd0);
    check("R12 checkstop", {31'b0, checkstop}, 32'd0);
    check("R12 target", redirect_addr, 32'd0);
    check("R12 save0", save0, 32'd0);
    check("R12 save1", save1, 32'd0);
    check("R12 state", new_state, 32'd0);
    e_addr = 0; e_s0 = 0; e_s1 = 0; e_st = 0; e_cs = 0;

    for (int c = 0; c < 1024; c++) begin
      logic [6:0]  trig;
      logic        me, ip, cor, sr, mc, take_sr, take_mc;
      logic [31:0] st, pc;
      string       tag;
      trig = c[6:0]; me = c[7]; ip = c[8]; cor = c[9];
      st = (c * 32'h9E37_79B9) ^ 32'h5A3C_96E1;
      st[31-19] = me;
      st[31-25] = ip;
      pc = (c * 32'h0001_0204) ^ 32'hC0DE_0000;

      @(negedge clk);
      soft_rst_req = trig[0]; hard_rst_req = trig[1]; mchk_pin = trig[2];
      xfer_err_ack = trig[3]; bus_addr_par_err = trig[4];
      bus_data_par_err = trig[5]; cache_par_err = trig[6];
      state_corrupt = cor; next_pc = pc; cur_state = st;

      sr = trig[0] | trig[1];
      mc = |trig[6:2];
      take_sr = sr;
      take_mc = !sr && mc && me;
      if (sr && mc)      tag = "R4";
      else if (sr)       tag = "R1";
      else if (mc && me) tag = "R2";
      else if (mc)       tag = "R3";
      else               tag = "R10";

      if (take_sr || take_mc) begin
        e_addr = (abit(st, 25) ? 32'hFFF0_0000 : 32'h0) + (take_sr ? 32'h100 : 32'h200);
        e_s0 = pc;
        e_s1 = exp_save1(st, cor);
        e_st = exp_state(st);
      end
      if (trig[1])        e_cs = 1'b0;
      else if (mc && !me) e_cs = 1'b1;

      @(negedge clk);
      check({tag, " strobe"}, {31'b0, redirect_vld}, {31'b0, take_sr || take_mc});
      check({tag, " R5 target"}, redirect_addr, e_addr);
      check({tag, " R6 save0"}, save0, e_s0);
      check({tag, cor ? " R8 save1" : " R7 save1"}, save1, e_s1);
      check({tag, " R9 state"}, new_state, e_st);
      check("R11 checkstop", {31'b0, checkstop}, {31'b0, e_cs});
      idle_inputs(pc * 32'h0000_0007 + 32'h55);

      @(negedge clk);
      check("R10 strobe drop", {31'b0, redirect_vld}, 32'd0);
      check("R10 hold save0", save0, e_s0);
      check("R10 hold state", new_state, e_st);
      check("R10 hold target", redirect_addr, e_addr);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule